// File: doc/BRIEF.md
# Scaled Integer / Binary64 Converter

This unit converts between signed 64-bit integers and binary64 floating-point values. A signed immediate acts as a power-of-two scale in either direction, so a fixed-point quantity converts in one operation with no multiply or divide.

It uses an adder-style datapath rather than a dedicated converter. For integer-to-float, the absolute value of the integer is treated as the mantissa of an unnormalized float. That float gets a synthesized exponent, the scale is added to it, and a leading-zero count then normalizes it. For float-to-integer, the significand is aligned against a fixed reference exponent, shifted by the scale, and read out before any normalization. The sign is applied afterwards as a two's-complement negation.

Both directions round by truncation. Results beyond the representable range saturate. There are no exception flags and no NaN treatment.

The unit is a three-stage pipeline that accepts one operation per cycle. A valid bit travels with each operation's data.

Top module: `fpint_scale_conv`

## Requirements
- R1: While reset is asserted and directly after it is released, `outValid` is 0 and `result` is all zeros.
- R2: An operation sampled with `inValid` high at rising edge n produces its result, with `outValid` high for exactly one cycle, after rising edge n+2. A new operation may be issued at every edge. `outValid` is low in every cycle that does not deliver a result.
- R3: With `toFloat`=1 (integer to float) and `scale`=0, every integer whose magnitude is below 2^53 converts to its exact binary64 encoding. The encoding is sign in bit 63, biased exponent (bias 1023) in bits 62:52 and fraction in bits 51:0. Both +/-(2^53-1) and -2^63 are exact.
- R4: With `toFloat`=1, the result is the value |x|·2^scale, where `scale` is 12-bit two's complement. Fraction bits below bit 0 of the 52-bit field are truncated. For example, 2^53+1 gives 2^53, and 2^63-1 gives exponent 1085 with an all-ones fraction.
- R5: With `toFloat`=1, an integer of 0 gives +0.0 (all 64 bits zero) for any scale.
- R6: With `toFloat`=1, a biased exponent of 2047 or more gives infinity with the input's sign. A biased exponent of 0 or less gives a zero with the input's sign.
- R7: With `toFloat`=0 (float to integer), the result is the input value times 2^scale, truncated toward zero. An example is 2.75 giving 2.
- R8: With `toFloat`=0, a negative input gives the two's-complement negation of the truncated magnitude. For example, -2.75 gives -2.
- R9: With `toFloat`=0, a scaled magnitude of 2^63 or more saturates to 0x7FFFFFFFFFFFFFFF for a positive input and to 0x8000000000000000 for a negative input. An exponent field of 2047 (infinity) saturates the same way. A scaled magnitude of 2^62 converts without saturation.
- R10: With `toFloat`=0, an exponent field of 0 (zero or subnormal, either sign) gives an integer result of 0 for any scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present on the inputs this cycle |
| toFloat | input | 1 | 1 = integer to binary64, 0 = binary64 to integer |
| operand | input | 64 | Signed integer or binary64 bit pattern |
| scale | input | 12 | Signed power-of-two scale (two's complement) |
| outValid | output | 1 | Result present this cycle |
| result | output | 64 | Converted value |

## Verification
Every result is due after the third rising edge, counting the edge that sampled its inputs. The bench drives inputs on a falling edge and checks on falling edges. For each operation it checks that `outValid` stays low on the first two falling edges. It then checks the value and `outValid` on the third falling edge, and checks that `outValid` has dropped on the fourth. A back-to-back run issues three operations on consecutive edges and expects the three results on consecutive falling edges, in issue order.

// File: rtl/fpint_conv_pkg.sv
package fpint_conv_pkg;

  // Strobes from the control pipeline to the datapath stages.
  typedef struct packed {
    logic s1En;       // load stage 1 registers
    logic s1ToFloat;  // direction of the operation entering stage 1
    logic s2En;       // load stage 2 registers
    logic s2ToFloat;  // direction of the operation held in stage 1
    logic s3En;       // load the result register
    logic s3ToFloat;  // direction of the operation held in stage 2
  } convStrobes_t;

endpackage

// File: rtl/fpint_conv_ctrl.sv
module fpint_conv_ctrl
  import fpint_conv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         toFloat,
  output convStrobes_t str,
  output logic         outValid
);

  logic v1, v2, v3;
  logic m1, m2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      m1 <= 1'b0;
      m2 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
      if (inValid) m1 <= toFloat;
      if (v1)      m2 <= m1;
    end
  end

  always_comb begin
    str.s1En      = inValid;
    str.s1ToFloat = toFloat;
    str.s2En      = v1;
    str.s2ToFloat = m1;
    str.s3En      = v2;
    str.s3ToFloat = m2;
  end

  assign outValid = v3;

  // R2: an issued operation surfaces exactly three edges later
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

  // R2: no result without a matching issue
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid);

endmodule

// File: rtl/fpint_conv_dp.sv
module fpint_conv_dp
  import fpint_conv_pkg::*;
#(
  parameter int ExpW   = 11,
  parameter int FracW  = 52,
  parameter int ScaleW = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  convStrobes_t             str,
  input  logic [ExpW+FracW:0]      operand,
  input  logic signed [ScaleW-1:0] scale,
  output logic [ExpW+FracW:0]      result
);

  localparam int IntW    = 1 + ExpW + FracW;
  localparam int SigW    = FracW + 1;
  localparam int EW      = ((ExpW > ScaleW) ? ExpW : ScaleW) + 3;
  localparam int LzW     = $clog2(IntW);
  localparam int Bias    = 2 ** (ExpW - 1) - 1;
  localparam int MaxExp  = 2 ** ExpW - 1;
  localparam int IntBase = Bias + IntW - 1;
  localparam int FltBase = Bias + FracW;
  localparam int SatSh   = IntW - SigW;

  localparam logic signed [EW-1:0] IntBaseS = EW'(IntBase);
  localparam logic signed [EW-1:0] FltBaseS = EW'(FltBase);
  localparam logic signed [EW-1:0] SatShS   = EW'(SatSh);
  localparam logic signed [EW-1:0] MaxExpS  = EW'(MaxExp);
  localparam logic signed [EW-1:0] NegIntWS = -EW'(IntW);
  localparam logic signed [EW-1:0] ZeroS    = '0;

  function automatic logic [LzW:0] leadZeros(input logic [IntW-1:0] v);
    logic [LzW:0] n;
    logic         hit;
    n   = '0;
    hit = 1'b0;
    for (int i = IntW - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n   = n + 1'b1;
      end
    end
    return n;
  endfunction

  // ---------------- stage 1: operand synthesis ----------------
  logic                 opSign;
  logic [ExpW-1:0]      opExp;
  logic [FracW-1:0]     opFrac;
  logic signed [EW-1:0] scaleExt;
  logic [IntW-1:0]      mag1;
  logic signed [EW-1:0] exp1;
  logic                 zero1, inf1;

  logic [IntW-1:0]      s1Mag;
  logic signed [EW-1:0] s1Exp;
  logic                 s1Sign, s1Zero, s1Inf;

  always_comb begin
    opSign   = operand[IntW-1];
    opExp    = operand[IntW-2:FracW];
    opFrac   = operand[FracW-1:0];
    scaleExt = EW'(scale);
    if (str.s1ToFloat) begin
      mag1  = opSign ? (~operand + 1'b1) : operand;
      exp1  = IntBaseS + scaleExt;
      zero1 = (operand == '0);
      inf1  = 1'b0;
    end else begin
      mag1  = {{(IntW-SigW){1'b0}}, (opExp != '0), opFrac};
      exp1  = $signed({{(EW-ExpW){1'b0}}, opExp}) - FltBaseS + scaleExt;
      zero1 = (opExp == '0);
      inf1  = (opExp == {ExpW{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Mag  <= '0;
      s1Exp  <= '0;
      s1Sign <= 1'b0;
      s1Zero <= 1'b0;
      s1Inf  <= 1'b0;
    end else if (str.s1En) begin
      s1Mag  <= mag1;
      s1Exp  <= exp1;
      s1Sign <= opSign;
      s1Zero <= zero1;
      s1Inf  <= inf1;
    end
  end

  // ---------------- stage 2: normalize or align ----------------
  logic [LzW:0]         lz;
  logic signed [EW-1:0] negExp;
  logic [IntW-1:0]      mag2;
  logic signed [EW-1:0] exp2;
  logic                 sat2;

  logic [IntW-1:0]      s2Mag;
  logic signed [EW-1:0] s2Exp;
  logic                 s2Sign, s2Zero, s2Sat;

  always_comb begin
    lz     = leadZeros(s1Mag);
    negExp = -s1Exp;
    mag2   = '0;
    exp2   = s1Exp;
    sat2   = 1'b0;
    if (str.s2ToFloat) begin
      mag2 = s1Mag << lz[LzW-1:0];
      exp2 = s1Exp - $signed({{(EW-LzW-1){1'b0}}, lz});
    end else if (s1Zero) begin
      mag2 = '0;
    end else if (s1Inf || (s1Exp >= SatShS)) begin
      sat2 = 1'b1;
    end else if (s1Exp >= ZeroS) begin
      mag2 = s1Mag << s1Exp[LzW-1:0];
    end else if (s1Exp > NegIntWS) begin
      mag2 = s1Mag >> negExp[LzW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Mag  <= '0;
      s2Exp  <= '0;
      s2Sign <= 1'b0;
      s2Zero <= 1'b0;
      s2Sat  <= 1'b0;
    end else if (str.s2En) begin
      s2Mag  <= mag2;
      s2Exp  <= exp2;
      s2Sign <= s1Sign;
      s2Zero <= s1Zero;
      s2Sat  <= sat2;
    end
  end

  // ---------------- stage 3: pack, sign and saturate ----------------
  logic [IntW-1:0] res3;
  logic            expHigh, expLow;

  always_comb begin
    expHigh = (s2Exp >= MaxExpS);
    expLow  = (s2Exp <= ZeroS);
    if (str.s3ToFloat) begin
      if (s2Zero)       res3 = '0;
      else if (expHigh) res3 = {s2Sign, {ExpW{1'b1}}, {FracW{1'b0}}};
      else if (expLow)  res3 = {s2Sign, {(IntW-1){1'b0}}};
      else              res3 = {s2Sign, s2Exp[ExpW-1:0], s2Mag[IntW-2 -: FracW]};
    end else begin
      if (s2Sat)        res3 = s2Sign ? {1'b1, {(IntW-1){1'b0}}} : {1'b0, {(IntW-1){1'b1}}};
      else if (s2Sign)  res3 = ~s2Mag + 1'b1;
      else              res3 = s2Mag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         result <= '0;
    else if (str.s3En) result <= res3;
  end

  // R3: a nonzero integer leaves stage 2 with its leading one at the top
  a_r3_normalized: assert property (@(posedge clk) disable iff (!rstN)
    (str.s2En && str.s2ToFloat && !s1Zero) |=> s2Mag[IntW-1]);

  // R5: an integer zero packs to +0.0
  a_r5_int_zero: assert property (@(posedge clk) disable iff (!rstN)
    (str.s3En && str.s3ToFloat && s2Zero) |=> (result == '0));

  // R6: exponent overflow packs to infinity
  a_r6_overflow_inf: assert property (@(posedge clk) disable iff (!rstN)
    (str.s3En && str.s3ToFloat && !s2Zero && expHigh) |=>
      (result[IntW-2:0] == {{ExpW{1'b1}}, {FracW{1'b0}}}));

  // R9: a saturating float gives one of the two integer extremes
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (str.s3En && !str.s3ToFloat && s2Sat) |=>
      ((result == {1'b0, {(IntW-1){1'b1}}}) || (result == {1'b1, {(IntW-1){1'b0}}})));

  // R10: a zero or subnormal float aligns to a zero magnitude
  a_r10_zero_in: assert property (@(posedge clk) disable iff (!rstN)
    (str.s2En && !str.s2ToFloat && s1Zero) |=> ((s2Mag == '0) && !s2Sat));

endmodule

// File: rtl/fpint_scale_conv.sv
module fpint_scale_conv
  import fpint_conv_pkg::*;
#(
  parameter int ExpW   = 11,
  parameter int FracW  = 52,
  parameter int ScaleW = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     toFloat,
  input  logic [ExpW+FracW:0]      operand,
  input  logic signed [ScaleW-1:0] scale,
  output logic                     outValid,
  output logic [ExpW+FracW:0]      result
);

  convStrobes_t str;

  fpint_conv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .toFloat  (toFloat),
    .str      (str),
    .outValid (outValid)
  );

  fpint_conv_dp #(
    .ExpW   (ExpW),
    .FracW  (FracW),
    .ScaleW (ScaleW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .operand (operand),
    .scale   (scale),
    .result  (result)
  );

endmodule

// File: tb/fpint_scale_conv_tb.sv
`timescale 1ns/1ps
module fpint_scale_conv_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        toFloat = 1'b0;
  logic [63:0] operand = '0;
  logic [11:0] scale = '0;
  logic        outValid;
  logic [63:0] result;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fpint_scale_conv u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .toFloat  (toFloat),
    .operand  (operand),
    .scale    (scale),
    .outValid (outValid),
    .result   (result)
  );

  typedef struct packed {
    logic        toF;
    logic [63:0] op;
    logic [11:0] sc;
    logic [63:0] want;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    // R3: exact integer to float
    '{1'b1, 64'h0000000000000001, 12'h000, 64'h3FF0000000000000, 4'd3},
    '{1'b1, 64'hFFFFFFFFFFFFFFFF, 12'h000, 64'hBFF0000000000000, 4'd3},
    '{1'b1, 64'h0000000000000003, 12'h000, 64'h4008000000000000, 4'd3},
    '{1'b1, 64'h00000000000003E8, 12'h000, 64'h408F400000000000, 4'd3},
    '{1'b1, 64'h001FFFFFFFFFFFFF, 12'h000, 64'h433FFFFFFFFFFFFF, 4'd3},
    '{1'b1, 64'h8000000000000000, 12'h000, 64'hC3E0000000000000, 4'd3},
    // R4: truncation and scaling
    '{1'b1, 64'h0020000000000001, 12'h000, 64'h4340000000000000, 4'd4},
    '{1'b1, 64'h7FFFFFFFFFFFFFFF, 12'h000, 64'h43DFFFFFFFFFFFFF, 4'd4},
    '{1'b1, 64'h0000000000000003, 12'hFFE, 64'h3FE8000000000000, 4'd4},
    '{1'b1, 64'h0000000000000001, 12'h00A, 64'h4090000000000000, 4'd4},
    '{1'b1, 64'h0000000000000001, 12'hC02, 64'h0010000000000000, 4'd4},
    '{1'b1, 64'h0000000000000001, 12'h3FF, 64'h7FE0000000000000, 4'd4},
    // R5: integer zero
    '{1'b1, 64'h0000000000000000, 12'h000, 64'h0000000000000000, 4'd5},
    '{1'b1, 64'h0000000000000000, 12'h005, 64'h0000000000000000, 4'd5},
    // R6: exponent overflow and underflow
    '{1'b1, 64'h0000000000000001, 12'h400, 64'h7FF0000000000000, 4'd6},
    '{1'b1, 64'hFFFFFFFFFFFFFFFF, 12'h400, 64'hFFF0000000000000, 4'd6},
    '{1'b1, 64'hFFFFFFFFFFFFFFFF, 12'hC01, 64'h8000000000000000, 4'd6},
    '{1'b1, 64'h0000000000000001, 12'h830, 64'h0000000000000000, 4'd6},
    // R7: float to integer, truncation and scale
    '{1'b0, 64'h3FF0000000000000, 12'h000, 64'h0000000000000001, 4'd7},
    '{1'b0, 64'h4006000000000000, 12'h000, 64'h0000000000000002, 4'd7},
    '{1'b0, 64'h3FE0000000000000, 12'h000, 64'h0000000000000000, 4'd7},
    '{1'b0, 64'h408F400000000000, 12'h004, 64'h0000000000003E80, 4'd7},
    '{1'b0, 64'h408F400000000000, 12'hFFD, 64'h000000000000007D, 4'd7},
    '{1'b0, 64'h4006000000000000, 12'h002, 64'h000000000000000B, 4'd7},
    '{1'b0, 64'h433FFFFFFFFFFFFF, 12'h000, 64'h001FFFFFFFFFFFFF, 4'd7},
    '{1'b0, 64'h43D0000000000000, 12'h000, 64'h4000000000000000, 4'd7},
    '{1'b0, 64'h3FF0000000000000, 12'hF9C, 64'h0000000000000000, 4'd7},
    // R8: negative inputs
    '{1'b0, 64'hBFF0000000000000, 12'h000, 64'hFFFFFFFFFFFFFFFF, 4'd8},
    '{1'b0, 64'hC006000000000000, 12'h000, 64'hFFFFFFFFFFFFFFFE, 4'd8},
    '{1'b0, 64'hC08F400000000000, 12'h000, 64'hFFFFFFFFFFFFFC18, 4'd8},
    // R9: saturation, infinity, and the 2^62 boundary
    '{1'b0, 64'h43E0000000000000, 12'h000, 64'h7FFFFFFFFFFFFFFF, 4'd9},
    '{1'b0, 64'hC3E0000000000000, 12'h000, 64'h8000000000000000, 4'd9},
    '{1'b0, 64'h7FF0000000000000, 12'h000, 64'h7FFFFFFFFFFFFFFF, 4'd9},
    '{1'b0, 64'hFFF0000000000000, 12'h000, 64'h8000000000000000, 4'd9},
    '{1'b0, 64'h3FF0000000000000, 12'h03F, 64'h7FFFFFFFFFFFFFFF, 4'd9},
    '{1'b0, 64'h3FF0000000000000, 12'h03E, 64'h4000000000000000, 4'd9},
    // R10: zero and subnormal inputs
    '{1'b0, 64'h0000000000000001, 12'h000, 64'h0000000000000000, 4'd10},
    '{1'b0, 64'h8000000000000000, 12'h000, 64'h0000000000000000, 4'd10},
    '{1'b0, 64'h000FFFFFFFFFFFFF, 12'h3E8, 64'h0000000000000000, 4'd10},
    '{1'b0, 64'h0000000000000000, 12'h000, 64'h0000000000000000, 4'd10}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic toF, input logic [63:0] op, input logic [11:0] sc);
    inValid = 1'b1;
    toFloat = toF;
    operand = op;
    scale   = sc;
  endtask

  task automatic runOne(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    drive(v.toF, v.op, v.sc);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 valid early 1", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    check("R2 valid early 2", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    check("R2 valid due", {63'd0, outValid}, 64'd1);
    check(tag, result, v.want);
    @(negedge clk);
    check("R2 valid pulse end", {63'd0, outValid}, 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, outValid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {63'd0, outValid}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    for (int i = 0; i < NV; i++) runOne(VECS[i]);

    // R2: back-to-back issue, results in order on consecutive cycles
    @(negedge clk);
    drive(1'b1, 64'd1, 12'h000);
    @(negedge clk);
    drive(1'b0, 64'h3FF0000000000000, 12'h002);
    @(negedge clk);
    drive(1'b1, 64'd3, 12'h000);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 stream 1 valid", {63'd0, outValid}, 64'd1);
    check("R2 stream 1 R3", result, 64'h3FF0000000000000);
    @(negedge clk);
    check("R2 stream 2 valid", {63'd0, outValid}, 64'd1);
    check("R2 stream 2 R7", result, 64'd4);
    @(negedge clk);
    check("R2 stream 3 valid", {63'd0, outValid}, 64'd1);
    check("R2 stream 3 R3", result, 64'h4008000000000000);
    @(negedge clk);
    check("R2 stream idle", {63'd0, outValid}, 64'd0);

    // R1: reset mid-flight clears valid and result
    @(negedge clk);
    drive(1'b1, 64'd5, 12'h000);
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 valid mid reset", {63'd0, outValid}, 64'd0);
    check("R1 result mid reset", result, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no stale valid", {63'd0, outValid}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule